// File: doc/BRIEF.md
# Reset and Power-Mode Sequencer

This block produces the core's internal reset from a raw reset pin and runs the core through three operating states: run, idle and power-down. A reset is accepted only after the pin has been sampled high for a full qualification window. On the release edge of that reset, the block captures the external-access strap pin. Software enters a low-power state by strobing an idle or power-down request. The state begins only when the current instruction reports its completion.

In idle, the CPU clock enable drops while the peripherals keep their clock. Any pending enabled interrupt brings the core back to run. In power-down, the oscillator enable drops as well. Two things can end power-down. One is a hardware reset. The other is an external interrupt pin that is enabled and set to level mode, which wakes the core in two phases. While the pin is held low, the oscillator restarts. Once the pin is released, and after the oscillator and supply report good, the core returns to run with its registers intact.

A two-bit reset status value records two facts: whether a pin reset has happened since power-on, and whether the most recent pin reset ended a low-power state.

Top module: `pm_ctrl`

## Requirements
- R1: `core_rst` goes high after the rising clock edge that follows the 24th consecutive rising edge at which `rst_pin` was sampled high (24 = two machine cycles of 12 oscillator periods).
- R2: A high pulse on `rst_pin` that covers fewer than 24 sampling edges never raises `core_rst`. A single low sample restarts the count from zero.
- R3: While `arst_n` is low, and until `rst_pin` is first sampled low, `core_rst` is 1. During that time `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1 and `rst_stat` is 2'b00.
- R4: `xa_mode` takes the value of `xa_pin` at the clock edge where `core_rst` falls. After that, changes on `xa_pin` have no effect.
- R5: An idle or power-down request may arrive as a one-cycle strobe before the instruction ends. It is held, and the state changes only at an edge where `instr_end` is 1.
- R6: In idle, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1. When `irq_pending`=1, the next edge returns the block to run with `wake`=1 for exactly one cycle.
- R7: In power-down, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0. `irq_pending` has no effect on this state.
- R8: Power-down is left only for pin n with `ext_irq_en[n]`=1, `ext_irq_edge[n]`=0 (level mode) and `ext_irq_n[n]`=0. Pins that are disabled or in edge mode are ignored.
- R9: While the wake pin is held low, `osc_en`=1 and both clock enables stay 0. The block returns to run, with a one-cycle `wake` pulse and no `core_rst`, only when all level-mode enabled pins are high and `osc_stable` and `supply_ok` are both 1.
- R10: A qualified pin reset ends idle or power-down and leaves the block in run. In power-down, `osc_en` follows the sampled reset pin so that the qualification count can proceed.
- R11: If idle and power-down are requested together, power-down wins. Requests are consumed on entry, so after an exit the block stays in run even while `instr_end` stays high.
- R12: `rst_stat[0]` is set by each qualified pin reset. `rst_stat[1]` is loaded with 1 when a pin reset qualifies outside run and with 0 when it qualifies in run. `rst_stat[1]` is cleared by an interrupt wake from power-down. Both bits are 0 after `arst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, active high |
| xa_pin | input | 1 | External-access strap pin |
| idle_req | input | 1 | Idle request strobe from software |
| pd_req | input | 1 | Power-down request strobe from software |
| instr_end | input | 1 | Current instruction completes this cycle |
| irq_pending | input | 1 | Some enabled interrupt is pending |
| ext_irq_n | input | N_EXT | External interrupt pins, active low |
| ext_irq_en | input | N_EXT | Per-pin interrupt enable |
| ext_irq_edge | input | N_EXT | Per-pin mode, 1 = edge, 0 = level |
| osc_stable | input | 1 | Oscillator has settled |
| supply_ok | input | 1 | Supply is within operating range |
| core_rst | output | 1 | Internal reset to the core |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| wake | output | 1 | One-cycle pulse on interrupt exit from idle or power-down |
| xa_mode | output | 1 | Latched external-access strap |
| rst_stat | output | 2 | Reset status value |

## Verification
The reset pin is swept through every pulse length from 1 to 30 sampling edges. This separates the lengths that must not reset from the first length that must, at exactly 24. The power-down wake is tried with all sixteen enable and edge-mode settings of the two interrupt pins, both held low. This separates a real level-mode wake from pins that are disabled or in edge mode. Each real wake is then walked through both phases, with the oscillator-stable input held low after the pin is released. A reset issued from power-down, and a second wake after it, show how the status bits differ between reset exits and interrupt exits.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2,
    PM_WAKE = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
  parameter int QUAL_CYC = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  input  logic xa_pin,
  output logic rst_smp,
  output logic core_rst,
  output logic xa_lat
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYC);

  logic          smp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          xa_q, xa_d;
  logic          release_w;

  always_comb begin
    if (!smp_q)
      cnt_d = '0;
    else if (cnt_q != QMAX)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  assign release_w = (cnt_q == QMAX) && !smp_q;
  assign xa_d      = release_w ? xa_pin : xa_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      smp_q <= 1'b1;
      cnt_q <= QMAX;
      xa_q  <= 1'b0;
    end else begin
      smp_q <= rst_pin;
      cnt_q <= cnt_d;
      xa_q  <= xa_d;
    end
  end

  assign rst_smp  = smp_q;
  assign core_rst = (cnt_q == QMAX);
  assign xa_lat   = xa_q;

  // R2
  short_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!smp_q && !core_rst) |=> !core_rst);

  // R4
  xa_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !(core_rst && !smp_q) |=> $stable(xa_lat));
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             sync_rst,
  input  logic             rst_smp,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic             instr_end,
  input  logic             irq_pending,
  input  logic [N_EXT-1:0] ext_irq_n,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic [N_EXT-1:0] ext_irq_edge,
  input  logic             osc_stable,
  input  logic             supply_ok,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             wake,
  output logic             down_exit,
  output logic             low_pwr
);
  pm_state_e        state_q, state_d;
  logic             idle_p_q, idle_p_d;
  logic             pd_p_q, pd_p_d;
  logic             wake_q, wake_d;
  logic [N_EXT-1:0] lvl_low;
  logic             any_low, exit_ok, idle_want, pd_want;

  for (genvar i = 0; i < N_EXT; i++) begin : g_lvl
    assign lvl_low[i] = ext_irq_en[i] & ~ext_irq_edge[i] & ~ext_irq_n[i];
  end

  assign any_low   = |lvl_low;
  assign exit_ok   = !any_low && osc_stable && supply_ok;
  assign idle_want = idle_p_q | idle_req;
  assign pd_want   = pd_p_q | pd_req;

  always_comb begin
    state_d  = state_q;
    idle_p_d = idle_p_q;
    pd_p_d   = pd_p_q;
    wake_d   = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        idle_p_d = idle_want;
        pd_p_d   = pd_want;
        if (instr_end && (pd_want || idle_want)) begin
          state_d  = pd_want ? PM_DOWN : PM_IDLE;
          idle_p_d = 1'b0;
          pd_p_d   = 1'b0;
        end
      end
      PM_IDLE: begin
        if (irq_pending) begin
          state_d = PM_RUN;
          wake_d  = 1'b1;
        end
      end
      PM_DOWN: begin
        if (any_low) state_d = PM_WAKE;
      end
      PM_WAKE: begin
        if (exit_ok) begin
          state_d = PM_RUN;
          wake_d  = 1'b1;
        end
      end
      default: state_d = PM_RUN;
    endcase
    if (sync_rst) begin
      state_d  = PM_RUN;
      idle_p_d = 1'b0;
      pd_p_d   = 1'b0;
      wake_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= PM_RUN;
      idle_p_q <= 1'b0;
      pd_p_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idle_p_q <= idle_p_d;
      pd_p_q   <= pd_p_d;
      wake_q   <= wake_d;
    end
  end

  assign cpu_clk_en = (state_q == PM_RUN);
  assign per_clk_en = (state_q == PM_RUN) || (state_q == PM_IDLE);
  assign osc_en     = (state_q == PM_DOWN) ? rst_smp : 1'b1;
  assign wake       = wake_q;
  assign down_exit  = (state_q == PM_WAKE) && exit_ok && !sync_rst;
  assign low_pwr    = (state_q != PM_RUN);

  // R5
  entry_at_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == PM_RUN && !instr_end) |=> (state_q == PM_RUN));

  // R7
  down_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == PM_DOWN && !any_low && !sync_rst) |=> (state_q == PM_DOWN));
endmodule

// File: rtl/pm_rst_status.sv
module pm_rst_status (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       core_rst,
  input  logic       low_pwr,
  input  logic       down_exit,
  output logic [1:0] rst_stat
);
  logic       rst_d_q;
  logic [1:0] stat_q, stat_d;
  logic       new_rst;

  assign new_rst = core_rst && !rst_d_q;

  always_comb begin
    stat_d = stat_q;
    if (new_rst) begin
      stat_d[0] = 1'b1;
      stat_d[1] = low_pwr;
    end else if (down_exit) begin
      stat_d[1] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_d_q <= 1'b1;
      stat_q  <= 2'b00;
    end else begin
      rst_d_q <= core_rst;
      stat_q  <= stat_d;
    end
  end

  assign rst_stat = stat_q;

  // R12
  stat_pin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_stat[0]) |-> 1'b0);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl #(
  parameter int QUAL_CYC = 24,
  parameter int N_EXT    = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_pin,
  input  logic             xa_pin,
  input  logic             idle_req,
  input  logic             pd_req,
  input  logic             instr_end,
  input  logic             irq_pending,
  input  logic [N_EXT-1:0] ext_irq_n,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic [N_EXT-1:0] ext_irq_edge,
  input  logic             osc_stable,
  input  logic             supply_ok,
  output logic             core_rst,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             wake,
  output logic             xa_mode,
  output logic [1:0]       rst_stat
);
  logic rst_smp, down_exit, low_pwr;

  pm_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk      (clk),
    .arst_n   (arst_n),
    .rst_pin  (rst_pin),
    .xa_pin   (xa_pin),
    .rst_smp  (rst_smp),
    .core_rst (core_rst),
    .xa_lat   (xa_mode)
  );

  pm_mode_fsm #(.N_EXT(N_EXT)) u_fsm (
    .clk          (clk),
    .arst_n       (arst_n),
    .sync_rst     (core_rst),
    .rst_smp      (rst_smp),
    .idle_req     (idle_req),
    .pd_req       (pd_req),
    .instr_end    (instr_end),
    .irq_pending  (irq_pending),
    .ext_irq_n    (ext_irq_n),
    .ext_irq_en   (ext_irq_en),
    .ext_irq_edge (ext_irq_edge),
    .osc_stable   (osc_stable),
    .supply_ok    (supply_ok),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_en       (osc_en),
    .wake         (wake),
    .down_exit    (down_exit),
    .low_pwr      (low_pwr)
  );

  pm_rst_status u_stat (
    .clk       (clk),
    .arst_n    (arst_n),
    .core_rst  (core_rst),
    .low_pwr   (low_pwr),
    .down_exit (down_exit),
    .rst_stat  (rst_stat)
  );

  // R7
  osc_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));

  // R9
  wake_clean_chk: assert property (@(posedge clk) disable iff (!arst_n)
    wake |-> (!core_rst && cpu_clk_en));

  // R1
  rst_needs_pin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst) |-> $past(rst_smp));
endmodule

// File: tb/pm_ctrl_tb.sv
module pm_ctrl_tb;
  logic       clk = 1'b0;
  logic       arst_n, rst_pin, xa_pin, idle_req, pd_req, instr_end, irq_pending;
  logic [1:0] ext_irq_n, ext_irq_en, ext_irq_edge;
  logic       osc_stable, supply_ok;
  logic       core_rst, cpu_clk_en, per_clk_en, osc_en, wake, xa_mode;
  logic [1:0] rst_stat;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  pm_ctrl u_dut (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .xa_pin(xa_pin),
    .idle_req(idle_req), .pd_req(pd_req), .instr_end(instr_end),
    .irq_pending(irq_pending), .ext_irq_n(ext_irq_n), .ext_irq_en(ext_irq_en),
    .ext_irq_edge(ext_irq_edge), .osc_stable(osc_stable), .supply_ok(supply_ok),
    .core_rst(core_rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .wake(wake), .xa_mode(xa_mode), .rst_stat(rst_stat)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pin_reset(input int len);
    rst_pin = 1'b1;
    repeat (len) tick();
    rst_pin = 1'b0;
    repeat (3) tick();
  endtask

  task automatic enter_mode(input bit idl, input bit pd);
    idle_req = idl; pd_req = pd; instr_end = 1'b1;
    tick();
    idle_req = 1'b0; pd_req = 1'b0; instr_end = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    arst_n = 1'b0; rst_pin = 1'b0; xa_pin = 1'b1; idle_req = 1'b0; pd_req = 1'b0;
    instr_end = 1'b0; irq_pending = 1'b0; ext_irq_n = 2'b11; ext_irq_en = 2'b00;
    ext_irq_edge = 2'b00; osc_stable = 1'b0; supply_ok = 1'b0;
    #35;
    // R3 power-on state
    chk("R3 core_rst in reset", core_rst, 1);
    chk("R3 enables in reset", {cpu_clk_en, per_clk_en, osc_en}, 7);
    chk("R3 status after por", rst_stat, 0);
    tick();
    arst_n = 1'b1;
    chk("R3 core_rst held", core_rst, 1);
    repeat (3) tick();
    chk("R3 core_rst released", core_rst, 0);
    chk("R4 strap at release", xa_mode, 1);

    // R1 / R2 sweep of pulse lengths
    for (int len = 1; len <= 30; len++) begin
      bit seen = 1'b0;
      rst_pin = 1'b1;
      for (int k = 0; k < len; k++) begin
        tick();
        seen |= core_rst;
      end
      rst_pin = 1'b0;
      for (int k = 0; k < 3; k++) begin
        tick();
        seen |= core_rst;
      end
      if (len < 24) chk($sformatf("R2 short pulse len=%0d", len), seen, 0);
      else          chk($sformatf("R1 pulse len=%0d", len), seen, 1);
      if (len == 23) begin
        // R2 restart after a low sample: 23 high, 1 low, 23 high
        rst_pin = 1'b1; repeat (23) tick();
        rst_pin = 1'b0; tick();
        rst_pin = 1'b1;
        for (int k = 0; k < 23; k++) begin tick(); seen |= core_rst; end
        rst_pin = 1'b0; repeat (3) tick();
        chk("R2 count restart", seen, 0);
      end
    end
    chk("R12 status after run resets", rst_stat, 1);

    // R4 strap latched and later ignored
    xa_pin = 1'b0;
    pin_reset(26);
    chk("R4 strap low latched", xa_mode, 0);
    xa_pin = 1'b1;
    repeat (10) tick();
    chk("R4 strap change ignored", xa_mode, 0);

    // R5 request held until instruction end
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    repeat (3) tick();
    chk("R5 no entry before end", cpu_clk_en, 1);
    instr_end = 1'b1; tick(); instr_end = 1'b0;
    // R6 idle enables
    chk("R6 idle enables", {cpu_clk_en, per_clk_en, osc_en}, 3);
    repeat (3) tick();
    chk("R6 idle holds", cpu_clk_en, 0);
    irq_pending = 1'b1; tick(); irq_pending = 1'b0;
    chk("R6 idle exit", {cpu_clk_en, wake}, 3);
    tick();
    chk("R6 wake one cycle", wake, 0);
    // R11 requests consumed
    instr_end = 1'b1; repeat (3) tick(); instr_end = 1'b0;
    chk("R11 no re-entry", cpu_clk_en, 1);

    // R11 priority, R7 power-down
    enter_mode(1'b1, 1'b1);
    chk("R11 pd priority", {cpu_clk_en, per_clk_en, osc_en}, 0);
    irq_pending = 1'b1; repeat (3) tick(); irq_pending = 1'b0;
    chk("R7 irq_pending ignored", {cpu_clk_en, per_clk_en, osc_en}, 0);

    // R8 / R9 sweep of pin configurations
    for (int cfg = 0; cfg < 16; cfg++) begin
      bit exp;
      ext_irq_en = cfg[3:2]; ext_irq_edge = cfg[1:0];
      exp = |(ext_irq_en & ~ext_irq_edge);
      ext_irq_n = 2'b00;
      tick();
      chk($sformatf("R8 cfg=%0d osc_en", cfg), osc_en, exp);
      ext_irq_n = 2'b11;
      tick();
      if (exp) begin
        chk($sformatf("R9 cfg=%0d waits stable", cfg), {cpu_clk_en, osc_en}, 1);
        osc_stable = 1'b1; supply_ok = 1'b1;
        tick();
        chk($sformatf("R9 cfg=%0d exit", cfg), {cpu_clk_en, wake, core_rst}, 6);
        osc_stable = 1'b0; supply_ok = 1'b0;
        enter_mode(1'b0, 1'b1);
      end else begin
        chk($sformatf("R8 cfg=%0d stays down", cfg), {cpu_clk_en, osc_en}, 0);
      end
    end

    // R10 pin reset ends power-down, R12 status
    rst_pin = 1'b1; tick();
    chk("R10 osc_en on reset pin", osc_en, 1);
    repeat (25) tick();
    rst_pin = 1'b0; repeat (3) tick();
    chk("R10 run after reset", {core_rst, cpu_clk_en}, 1);
    chk("R12 reset from power-down", rst_stat, 3);
    enter_mode(1'b0, 1'b1);
    ext_irq_en = 2'b10; ext_irq_edge = 2'b00; ext_irq_n = 2'b01;
    tick();
    ext_irq_n = 2'b11; osc_stable = 1'b1; supply_ok = 1'b1;
    tick();
    chk("R9 second wake", cpu_clk_en, 1);
    tick();
    chk("R12 interrupt wake clears bit", rst_stat, 1);
    // R10 reset ends idle
    enter_mode(1'b1, 1'b0);
    pin_reset(26);
    chk("R10 idle ended by reset", {cpu_clk_en, rst_stat}, 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule